// File: doc/BRIEF.md
# Last-Value Fast Channel Bank

This block is a small RAM of fast channels that sits between a sending agent and a receiving agent. The sender can overwrite any channel word at any moment, with no handshake. It does not wait for the receiver to have read the previous value. The receiver reads through its own port and always gets the most recent word. Values that were overwritten before anyone read them are gone.

Every accepted sender write marks that channel as pending. From the pending bits and a per-channel enable vector the block drives level-sensitive interrupts. There is one interrupt per group of consecutive channels, and, when a parameter selects it, one interrupt per channel. The receiver acknowledges a channel by pulsing a clear for its index. The word size is 32 or 64 bits, and byte enables allow partial-word updates.

Top module: `fastchan_bank`

## Requirements
- R1: After reset every channel word reads zero, all pending bits are 0 and every interrupt output is low.
- R2: A read of channel `rd_idx` shows on `rd_data` one clock later and returns the last value written to that channel. Repeated writes with no read in between leave only the newest value.
- R3: A write changes only the bytes whose `wr_be` bit is 1. Byte lane b covers data bits 8b+7 down to 8b. A write with `wr_be` all zero leaves the word unchanged.
- R4: A read and a write to the same channel in the same cycle return the value held before that write.
- R5: An in-range sender write sets the pending bit of the written channel and of no other channel, whatever the byte enables.
- R6: A clear pulse (`clr_en` with `clr_idx`) drops that channel's pending bit. If a write to the same channel happens in the same cycle, the bit stays set.
- R7: Group g covers channels g*GROUP_SIZE up to min((g+1)*GROUP_SIZE, NUM_CH)-1. `grp_irq[g]` is the OR of pending AND `irq_en` over that group.
- R8: With CH_IRQ_EN=1, `ch_irq` equals pending AND `irq_en`. With CH_IRQ_EN=0, `ch_irq` is always zero.
- R9: A write, read or clear with an index of NUM_CH or above has no effect on any word or pending bit. Such a read returns zero.
- R10: The interrupts are levels. Once asserted, an interrupt stays high until its pending bit is cleared or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Sender write strobe |
| wr_idx | input | IDX_W | Channel written by the sender |
| wr_data | input | WORD_BITS | Sender write data |
| wr_be | input | WORD_BITS/8 | Byte enables of the write |
| rd_idx | input | IDX_W | Channel read by the receiver |
| rd_data | output | WORD_BITS | Registered read data |
| clr_en | input | 1 | Receiver clear strobe |
| clr_idx | input | IDX_W | Channel whose pending bit is cleared |
| irq_en | input | NUM_CH | Per-channel interrupt enables |
| pending | output | NUM_CH | Per-channel pending bits |
| ch_irq | output | NUM_CH | Per-channel interrupts |
| grp_irq | output | NUM_GRP | Group interrupts |

## Verification
The bench uses 64-bit words, 12 channels and a group size of 5. The index is 4 bits wide, so indices 12 to 15 exercise the out-of-range path, and the last group holds only two channels. Two copies of the block share one set of inputs: one with per-channel interrupts and one without. This lets a single stimulus stream check both interrupt variants. The small channel count makes it possible to sweep writes, reads and clears over every index, including the unused ones, and over several byte-enable patterns.

// File: rtl/fastchan_bank.sv
`timescale 1ns/1ps
module fastchan_bank #(
  parameter int WORD_BITS  = 32,
  parameter int NUM_CH     = 64,
  parameter int GROUP_SIZE = 32,
  parameter bit CH_IRQ_EN  = 1'b1,
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BE_W    = WORD_BITS / 8,
  localparam int NUM_GRP = (NUM_CH + GROUP_SIZE - 1) / GROUP_SIZE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic [BE_W-1:0]      wr_be,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [WORD_BITS-1:0] rd_data,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic [NUM_CH-1:0]    irq_en,
  output logic [NUM_CH-1:0]    pending,
  output logic [NUM_CH-1:0]    ch_irq,
  output logic [NUM_GRP-1:0]   grp_irq
);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(NUM_CH);

  logic [WORD_BITS-1:0] mem [NUM_CH];
  logic [NUM_CH-1:0]    set_v, clr_v, act;

  wire wr_hit  = wr_en  && ({1'b0, wr_idx}  < LIM);
  wire clr_hit = clr_en && ({1'b0, clr_idx} < LIM);
  wire rd_hit  = {1'b0, rd_idx} < LIM;

  assign set_v = wr_hit  ? (NUM_CH'(1) << wr_idx)  : '0;
  assign clr_v = clr_hit ? (NUM_CH'(1) << clr_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) mem[c] <= '0;
    end else if (wr_hit) begin
      for (int b = 0; b < BE_W; b++)
        if (wr_be[b]) mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_hit ? mem[rd_idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else        pending <= set_v | (pending & ~clr_v);
  end

  assign act = pending & irq_en;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = g * GROUP_SIZE;
    localparam int HI = ((LO + GROUP_SIZE) < NUM_CH) ? (LO + GROUP_SIZE - 1) : (NUM_CH - 1);
    assign grp_irq[g] = |act[HI:LO];
  end

  if (CH_IRQ_EN) begin : g_chirq
    assign ch_irq = act;
  end else begin : g_nochirq
    assign ch_irq = '0;
  end
endmodule

// File: rtl/fastchan_bank_chk.sv
`timescale 1ns/1ps
module fastchan_bank_chk #(
  parameter int NUM_CH  = 64,
  parameter int IDX_W   = 6,
  parameter int NUM_GRP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               clr_en,
  input logic [IDX_W-1:0]   clr_idx,
  input logic [NUM_CH-1:0]  pending,
  input logic [NUM_CH-1:0]  ch_irq,
  input logic [NUM_GRP-1:0] grp_irq
);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(NUM_CH);

  a_r5_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ({1'b0, wr_idx} < LIM)) |=> pending[$past(wr_idx)]);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((pending & ~$past(pending)) == '0));

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ({1'b0, clr_idx} < LIM) && !(wr_en && wr_idx == clr_idx))
      |=> !pending[$past(clr_idx)]);

  a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !({1'b0, wr_idx} < LIM) && !clr_en) |=> (pending == $past(pending)));

  a_r8_ch_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_irq & ~pending) == '0));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (grp_irq == '0));
endmodule

bind fastchan_bank fastchan_bank_chk #(
  .NUM_CH(NUM_CH), .IDX_W(IDX_W), .NUM_GRP(NUM_GRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .clr_en(clr_en), .clr_idx(clr_idx), .pending(pending),
  .ch_irq(ch_irq), .grp_irq(grp_irq)
);

// File: tb/test_fastchan_bank.sv
`timescale 1ns/1ps
module test_fastchan_bank;
  localparam int W = 64, NCH = 12, GS = 5, NG = 3, IW = 4, BW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, clr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0, clr_idx = '0;
  logic [W-1:0] wr_data = '0;
  logic [BW-1:0] wr_be = '0;
  logic [NCH-1:0] irq_en = '1;
  logic [W-1:0] rd_data, rd_data_b;
  logic [NCH-1:0] pending, ch_irq, pending_b, ch_irq_b;
  logic [NG-1:0] grp_irq, grp_irq_b;

  int ntests = 0, nfail = 0;
  logic [W-1:0] mdl [NCH];
  logic [NCH-1:0] pend = '0;

  always #5 clk = ~clk;

  fastchan_bank #(.WORD_BITS(W), .NUM_CH(NCH), .GROUP_SIZE(GS), .CH_IRQ_EN(1'b1)) i_fastchan_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
    .rd_idx(rd_idx), .rd_data(rd_data), .clr_en(clr_en), .clr_idx(clr_idx), .irq_en(irq_en),
    .pending(pending), .ch_irq(ch_irq), .grp_irq(grp_irq));

  fastchan_bank #(.WORD_BITS(W), .NUM_CH(NCH), .GROUP_SIZE(GS), .CH_IRQ_EN(1'b0)) i_fastchan_bank_noch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
    .rd_idx(rd_idx), .rd_data(rd_data_b), .clr_en(clr_en), .clr_idx(clr_idx), .irq_en(irq_en),
    .pending(pending_b), .ch_irq(ch_irq_b), .grp_irq(grp_irq_b));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_grp();
    logic [NG-1:0] r = '0;
    for (int c = 0; c < NCH; c++) if (pend[c] && irq_en[c]) r[c / GS] = 1'b1;
    return r;
  endfunction

  task automatic check_irqs();
    chk("R5 pending", W'(pending), W'(pend));
    chk("R7 grp_irq", W'(grp_irq), W'(exp_grp()));
    chk("R8 ch_irq", W'(ch_irq), W'(pend & irq_en));
    chk("R8 ch_irq off variant", W'(ch_irq_b), '0);
    chk("R7 grp_irq off variant", W'(grp_irq_b), W'(exp_grp()));
  endtask

  task automatic cyc(input bit we, input int wi, input logic [W-1:0] wd, input logic [BW-1:0] be,
                     input int ri, input bit ce, input int ci, input string tag);
    logic [W-1:0] exp_rd;
    @(negedge clk);
    wr_en = we; wr_idx = IW'(wi); wr_data = wd; wr_be = be;
    rd_idx = IW'(ri); clr_en = ce; clr_idx = IW'(ci);
    exp_rd = (ri < NCH) ? mdl[ri] : '0;
    @(posedge clk);
    if (ce && ci < NCH) pend[ci] = 1'b0;
    if (we && wi < NCH) begin
      pend[wi] = 1'b1;
      for (int b = 0; b < BW; b++) if (be[b]) mdl[wi][8*b +: 8] = wd[8*b +: 8];
    end
    #1;
    chk(tag, rd_data, exp_rd);
    chk({tag, " second copy"}, rd_data_b, exp_rd);
    check_irqs();
    wr_en = 1'b0; clr_en = 1'b0;
  endtask

  function automatic logic [W-1:0] pat(input int c, input int k);
    return {32'(c * 32'h01010101 + k), 32'hA5000000 ^ 32'(c << 8) ^ 32'(k)};
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) mdl[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset rd_data", rd_data, '0);
    check_irqs();
    for (int c = 0; c < 16; c++) cyc(0, 0, '0, '0, c, 0, 0, "R1 reset read");

    // R2/R5 write sweep, then read back
    for (int c = 0; c < NCH; c++) cyc(1, c, pat(c, 1), '1, 0, 0, 0, "R5 sweep write");
    for (int c = 0; c < NCH; c++) cyc(0, 0, '0, '0, c, 0, 0, "R2 read back");

    // R6 clear sweep
    for (int c = 0; c < NCH; c++) cyc(0, 0, '0, '0, c, 1, c, "R6 clear sweep");

    // R2 overwrite without read
    cyc(1, 3, pat(3, 7), '1, 0, 0, 0, "R2 first write");
    cyc(1, 3, pat(3, 8), '1, 0, 0, 0, "R2 overwrite");
    cyc(0, 0, '0, '0, 3, 0, 0, "R2 newest value");

    // R3 byte-enable patterns
    for (int k = 0; k < 10; k++) begin
      logic [BW-1:0] be = (k == 0) ? 8'h00 : 8'((k * 37) ^ (1 << (k % 8)));
      cyc(1, 5, pat(9, k) ^ 64'hFFFF_0000_FFFF_0000, be, 0, 0, 0, "R3 partial write");
      cyc(0, 0, '0, '0, 5, 0, 0, "R3 merged word");
    end

    // R4 same-cycle read and write
    cyc(1, 7, pat(7, 3), '1, 7, 0, 0, "R4 old value on collision");
    cyc(0, 0, '0, '0, 7, 0, 0, "R4 new value next");

    // R6 write wins over clear
    cyc(1, 8, pat(8, 4), '1, 0, 1, 8, "R6 write beats clear");
    cyc(0, 0, '0, '0, 8, 1, 8, "R6 clear alone");

    // R9 out-of-range sweep
    for (int c = NCH; c < 16; c++) begin
      cyc(1, c, '1, '1, c, 1, c, "R9 out-of-range");
    end
    for (int c = 0; c < NCH; c++) cyc(0, 0, '0, '0, c, 0, 0, "R9 words untouched");

    // R7/R8/R10 mask patterns and level hold
    for (int c = 0; c < NCH; c++) cyc(1, c, pat(c, 5), '1, 0, 0, 0, "R7 fill");
    for (int k = 0; k < 8; k++) begin
      irq_en = NCH'(12'h5A3 >> k) ^ NCH'(k * 291);
      for (int n = 0; n < 2; n++) cyc(0, 0, '0, '0, 0, 0, 0, "R10 level hold");
    end
    irq_en = '1;
    for (int c = 0; c < NCH; c++) cyc(0, 0, '0, '0, 0, 1, c, "R10 drop by clear");

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule